// File: doc/BRIEF.md
# Time-base interval timer

This block keeps a free-running counter that advances once per main-clock cycle and turns it into a periodic interval event. Software chooses one of four counter taps, and the block sets an overflow flag each time the count bits below that tap roll over to zero. An interrupt request goes out while that flag is set and interrupts are enabled. The counter value itself is also driven out, so that other timing logic can use it.

Software reaches the block through a single 8-bit control/status register at address 0x0A on a simple register bus. The bus has an address, write data, a write strobe, a read strobe and a qualifier that marks a read as the first half of a read-modify-write. Both the flag and the counter are cleared by writing a zero to their bit, and writing a one to either bit does nothing. When a read is part of a read-modify-write, the flag bit reads as one. Writing that value back then leaves a pending flag in place.

The counter width and the four tap exponents are parameters. The defaults are a 22-bit counter with taps at 2^11, 2^12, 2^13 and 2^22. All bus pins are plain control and status signals. Reads are combinational and there is no back-pressure, so every strobe is accepted in the cycle it is given.

Top module: `tbase_timer`

## Requirements
- R1: After reset, the register reads 0x01 (flag 0, enable 0, select 00, bit 0 reads 1), `irq` is low and `tb_count` is zero.
- R2: `tb_count` goes up by one on every clock edge that has no counter-clear write, and wraps modulo 2^CNT_W.
- R3: Register bits 2:1 select the interval. Code 00 gives 2^TAP0_EXP cycles (default 11), 01 gives 2^TAP1_EXP (12), 10 gives 2^TAP2_EXP (13) and 11 gives 2^TAP3_EXP (22). The flag (bit 7) is set on the edge where the count bits below the selected tap roll over to zero.
- R4: A register write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged.
- R5: A plain read returns the actual flag in bit 7. A read with `bus_rmw` high returns 1 in bit 7.
- R6: `irq` is high exactly when the flag is 1 and the interrupt enable (bit 6) is 1.
- R7: A register write with bit 0 = 0 sets the counter to zero on that edge. A write with bit 0 = 1 leaves the counter running. Bit 0 always reads 1.
- R8: If the flag would be set by a rollover on the same edge as a flag-clear write, the flag ends up set.
- R9: Bits 5:3 always read 0, and writing to them has no effect.
- R10: Changing the select code does not touch the counter. The next flag comes at the next rollover of the newly selected tap.
- R11: Writes to any other address change nothing, and reads of any other address return 0x00.
- R12: A counter-clear write suppresses a rollover that would otherwise set the flag on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the current read as part of a read-modify-write |
| bus_rdata | output | 8 | Read data, combinational; 0 when no read hits the register |
| irq | output | 1 | Interval interrupt request |
| tb_count | output | CNT_W | Current time-base count |

## Verification
The interval is measured from a freshly cleared counter for each of the four select codes. The bench counts edges to the first interrupt and checks the count value at that moment, which separates the taps from one another and exposes an off-by-one in the rollover detection. A select change in the middle of a count shows whether the counter is kept and whether the new tap takes effect at once. A flag-clear write placed exactly on the setting edge separates set-priority from clear-priority. Plain and read-modify-write reads of a set flag, and writes to a neighbouring address, separate the read-back paths and the address decoding.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_TAPS);

  // register field positions (software view)
  localparam int unsigned B_FLAG   = 7;
  localparam int unsigned B_IE     = 6;
  localparam int unsigned B_SEL_HI = 2;
  localparam int unsigned B_SEL_LO = 1;
  localparam int unsigned B_CLR    = 0;

  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= count + 1'b1;
  end
endmodule

// File: rtl/tbase_tap_sel.sv
module tbase_tap_sel import tbase_pkg::*; #(
  parameter int CNT_W    = 22,
  parameter int TAP0_EXP = 11,
  parameter int TAP1_EXP = 12,
  parameter int TAP2_EXP = 13,
  parameter int TAP3_EXP = 22
) (
  input  logic [CNT_W-1:0] count,
  input  sel_t             sel,
  input  logic             cnt_clr,
  output logic             tick
);
  logic [NUM_TAPS-1:0] wrap;

  // one rollover detector per tap: low bits all ones means next edge wraps them
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int EXP = (i == 0) ? TAP0_EXP :
                         (i == 1) ? TAP1_EXP :
                         (i == 2) ? TAP2_EXP : TAP3_EXP;
    assign wrap[i] = &count[EXP-1:0];
  end

  // a clear on the same edge takes the counter elsewhere, so no rollover
  assign tick = wrap[sel] & ~cnt_clr;
endmodule

// File: rtl/tbase_ctlreg.sv
module tbase_ctlreg import tbase_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic             rd_rmw,
  input  logic             w_flag,
  input  logic             w_ie,
  input  sel_t             w_sel,
  input  logic             tick,
  output logic             flag,
  output logic             ie,
  output sel_t             sel,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ie   <= 1'b0;
      sel  <= '0;
    end else begin
      // hardware set has priority over a software clear
      if (tick)                 flag <= 1'b1;
      else if (wr_hit && !w_flag) flag <= 1'b0;
      if (wr_hit) begin
        ie  <= w_ie;
        sel <= w_sel;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      rdata[B_FLAG]            = flag | rd_rmw;
      rdata[B_IE]              = ie;
      rdata[B_SEL_HI:B_SEL_LO] = sel;
      rdata[B_CLR]             = 1'b1;
    end
  end
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer import tbase_pkg::*; #(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h0A,
  parameter int              CNT_W    = 22,
  parameter int              TAP0_EXP = 11,
  parameter int              TAP1_EXP = 12,
  parameter int              TAP2_EXP = 13,
  parameter int              TAP3_EXP = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_rmw,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic [CNT_W-1:0]  tb_count
);
  logic hit, wr_hit, rd_hit, cnt_clr, tick, flag, ie;
  sel_t sel;
  logic unused_wbits;

  assign hit          = (bus_addr == REG_ADDR);
  assign wr_hit       = bus_wr & hit;
  assign rd_hit       = bus_rd & hit;
  assign cnt_clr      = wr_hit & ~bus_wdata[B_CLR];
  assign unused_wbits = ^bus_wdata[5:3];

  tbase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .count (tb_count)
  );

  tbase_tap_sel #(
    .CNT_W(CNT_W), .TAP0_EXP(TAP0_EXP), .TAP1_EXP(TAP1_EXP),
    .TAP2_EXP(TAP2_EXP), .TAP3_EXP(TAP3_EXP)
  ) u_tap (
    .count   (tb_count),
    .sel     (sel),
    .cnt_clr (cnt_clr),
    .tick    (tick)
  );

  tbase_ctlreg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit),
    .rd_rmw (bus_rmw),
    .w_flag (bus_wdata[B_FLAG]),
    .w_ie   (bus_wdata[B_IE]),
    .w_sel  (bus_wdata[B_SEL_HI:B_SEL_LO]),
    .tick   (tick),
    .flag   (flag),
    .ie     (ie),
    .sel    (sel),
    .rdata  (bus_rdata)
  );

  assign irq = flag & ie;
endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h0A,
  parameter int              CNT_W    = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_rmw,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  tb_count
);
  logic hit_c, clr_wr_c;
  logic unused_chk;
  assign hit_c      = (bus_addr == REG_ADDR);
  assign clr_wr_c   = bus_wr && hit_c && !bus_wdata[0];
  assign unused_chk = ^bus_wdata[7:1];

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr_c |=> tb_count == CNT_W'($past(tb_count) + 1'b1));

  // R7
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_c |=> tb_count == '0);

  // R5
  rmw_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_rmw && hit_c) |-> bus_rdata[7]);

  // R7
  clr_bit_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_c) |-> bus_rdata[0]);

  // R9
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[5:3] == 3'b000);

  // R6
  irq_needs_flag_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_rmw && hit_c && irq) |-> (bus_rdata[7] && bus_rdata[6]));

  // R11
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit_c) |-> bus_rdata == 8'h00);
endmodule

bind tbase_timer tbase_timer_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_tbase_timer.sv
module sim_tbase_timer;
  localparam int CLK_P    = 10;
  localparam int CNT_W    = 15;
  localparam int TAP3_EXP = 15;
  localparam logic [7:0] RA = 8'h0A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0, irq;
  logic [CNT_W-1:0] tb_count;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tbase_timer #(.CNT_W(CNT_W), .TAP3_EXP(TAP3_EXP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
    .bus_rdata(bus_rdata), .irq(irq), .tb_count(tb_count));

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic rmw, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; bus_rmw = rmw;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; bus_rmw = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R1 count in reset", tb_count, 0);
    chk("R1 irq in reset", irq, 0);
    bus_addr = RA; bus_rd = 1'b1; #1;
    chk("R1 reset value", bus_rdata, 8'h01);
    bus_rd = 1'b0;
    rst_n = 1'b1;
    rd_reg(RA, 1'b0, d);
    chk("R1 after release", d, 8'h01);
  endtask

  task automatic t_count();
    logic [CNT_W-1:0] c0;
    @(negedge clk); c0 = tb_count;
    @(negedge clk); chk("R2 step", tb_count, CNT_W'(c0 + 1));
    c0 = tb_count;
    wr_reg(RA, 8'h01);  // bit0=1: no clear
    chk("R7 write 1 no clear", tb_count, CNT_W'(c0 + 2));
    wr_reg(RA, 8'h00);
    chk("R7 clear to zero", tb_count, 0);
  endtask

  // R3 interval measurement for one select code
  task automatic t_interval(input logic [1:0] code, input int k);
    logic [7:0] d;
    int n;
    longint expc;
    wr_reg(RA, {1'b0, 1'b1, 3'b000, code, 1'b0});
    n = 0;
    while (!irq && n < (1 << k) + 16) begin
      @(negedge clk); n++;
    end
    chk($sformatf("R3 period code %0d", code), n, 1 << k);
    expc = (longint'(1) << k) & ((longint'(1) << CNT_W) - 1);
    chk("R3 count at flag", tb_count, expc);
    rd_reg(RA, 1'b0, d);
    chk("R5 plain read flag", d[7], 1);
    chk("R3 select readback", d[2:1], code);
  endtask

  task automatic t_flag_ops();
    logic [7:0] d;
    // flag is set with ie=1, code 00 from previous test
    rd_reg(RA, 1'b1, d);
    chk("R5 rmw read flag", d[7], 1);
    wr_reg(RA, 8'hC1);  // bit7=1, ie=1, code 00
    rd_reg(RA, 1'b0, d);
    chk("R4 write 1 keeps flag", d[7], 1);
    chk("R6 irq with ie", irq, 1);
    wr_reg(RA, 8'h81);  // ie=0
    chk("R6 irq masked", irq, 0);
    rd_reg(RA, 1'b0, d);
    chk("R6 flag still set", d[7], 1);
    wr_reg(RA, 8'h41);  // clear flag, ie=1
    chk("R6 irq after clear", irq, 0);
    rd_reg(RA, 1'b0, d);
    chk("R4 write 0 clears flag", d[7], 0);
    rd_reg(RA, 1'b1, d);
    chk("R5 rmw read with flag 0", d[7], 1);
    rd_reg(RA, 1'b0, d);
    chk("R5 rmw read did not set", d[7], 0);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    int n;
    wr_reg(RA, 8'h40);  // clear flag and counter, ie=1, code 00
    n = 0;
    while (tb_count != CNT_W'(2047) && n < 3000) begin
      @(negedge clk); n++;
    end
    bus_addr = RA; bus_wdata = 8'h41; bus_wr = 1'b1;  // clear lands on setting edge
    @(negedge clk); bus_wr = 1'b0;
    rd_reg(RA, 1'b0, d);
    chk("R8 set wins over clear", d[7], 1);
    // counter clear on the rollover edge suppresses the set
    wr_reg(RA, 8'h40);
    n = 0;
    while (tb_count != CNT_W'(2047) && n < 3000) begin
      @(negedge clk); n++;
    end
    bus_addr = RA; bus_wdata = 8'h40; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd_reg(RA, 1'b0, d);
    chk("R12 clear suppresses set", d[7], 0);
    chk("R12 counter restarted", tb_count, 2);
  endtask

  task automatic t_sel_change();
    int n;
    wr_reg(RA, 8'h40);  // code 00, counter 0
    n = 0;
    while (tb_count != CNT_W'(100) && n < 300) begin
      @(negedge clk); n++;
    end
    bus_addr = RA; bus_wdata = 8'h45; bus_wr = 1'b1;  // code 10, no counter clear
    @(negedge clk); bus_wr = 1'b0;
    chk("R10 counter kept", tb_count, 101);
    n = 0;
    while (!irq && n < 9000) begin
      @(negedge clk); n++;
    end
    chk("R10 next flag at new tap", tb_count, 8192);
    chk("R10 wait length", n, 8192 - 101);
  endtask

  task automatic t_misc();
    logic [7:0] d;
    logic [CNT_W-1:0] c0;
    wr_reg(RA, 8'h7B);  // clear flag, ie=1, bits5:3 set, code 01, no clear
    rd_reg(RA, 1'b0, d);
    chk("R9 spare bits read 0", d, 8'h43);
    rd_reg(RA, 1'b1, d);
    chk("R9 spare bits on rmw", d, 8'hC3);
    @(negedge clk); c0 = tb_count;
    wr_reg(8'h0B, 8'h00);
    chk("R11 other address no clear", tb_count, CNT_W'(c0 + 2));
    rd_reg(RA, 1'b0, d);
    chk("R11 register unchanged", d, 8'h43);
    rd_reg(8'h0B, 1'b0, d);
    chk("R11 other address reads 0", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_count();
    t_interval(2'b00, 11);
    t_flag_ops();
    t_interval(2'b01, 12);
    t_interval(2'b10, 13);
    t_interval(2'b11, TAP3_EXP);
    t_set_wins();
    t_sel_change();
    t_misc();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule